// File: doc/BRIEF.md
# Master Serial Result Transmitter

This block sends a converter result as a serial word while it drives the serial clock itself. It derives the serial clock from the system clock by a fixed divider. It shifts the word out most significant bit first on one data line. It raises a frame-valid strobe for as long as the data line carries bits. Two option inputs flip the polarity of the serial clock and of the frame strobe. Chip-select and read-enable inputs force all three serial outputs to their inactive levels.

The block also owns the conversion-busy indication. A conversion-start pulse raises busy, and a conversion-done pulse, together with the result word, ends the conversion phase. With the mode input low, the new result is sent right after the conversion, and busy stays high until the last bit has left. With the mode input high, the word captured at the previous conversion-done is sent during the current conversion, starting one serial-clock period after the start. In that mode busy falls when the conversion ends. The block only acts as a master when the serial-select input is high and the external-clock select is low.

Top module: `sertx_master`

## Requirements
- R1: After reset, busy is 0, sdout is 0, sclk equals inv_sclk and sync equals inv_sync.
- R2: A frame is 16 serial-clock periods, each HALF_DIV system cycles low then HALF_DIV cycles high (before inversion). Bit k of the frame carries result bit 15-k for the whole of period k, so the data changes only where the clock falls.
- R3: Before inversion, sync is high for exactly the 32*HALF_DIV cycles of a frame. sdout is 0 whenever no frame runs.
- R4: inv_sclk=1 inverts sclk and inv_sync=1 inverts sync, both in frames and while idle.
- R5: With rdc_mode=0 at the accepted start, the frame begins in the cycle after conv_done is sampled high and carries that cycle's result. Busy stays 1 until the frame's last cycle and falls together with sync.
- R6: With rdc_mode=1, the frame begins 2*HALF_DIV cycles after the start is sampled. It carries the result stored at the previous accepted conv_done, or 0 after reset. Busy falls in the cycle after conv_done, even if the frame is still pending or running.
- R7: Busy rises in the cycle after an accepted conv_start. conv_start is ignored while busy is high or a frame is pending or running. rdc_mode is only sampled when a start is accepted.
- R8: conv_done is ignored while no conversion is in progress: busy is unchanged and the stored word keeps its value.
- R9: Frames are produced only when ser_sel=1 and ext_clk_sel=0. Otherwise busy falls in the cycle after conv_done in both modes, and the serial outputs stay idle.
- R10: While cs_n or rd_n is 1, sdout is 0, sclk equals inv_sclk and sync equals inv_sync. Internal timing and busy are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion-start pulse |
| conv_done | input | 1 | Conversion-end pulse; result is valid with it |
| result | input | 16 | Converted word |
| rdc_mode | input | 1 | 1: send previous word during the conversion; 0: send new word after it |
| inv_sclk | input | 1 | Invert serial clock |
| inv_sync | input | 1 | Invert frame strobe |
| ser_sel | input | 1 | Serial interface selected |
| ext_clk_sel | input | 1 | External serial clock selected (disables master frames) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| busy | output | 1 | Conversion (and read-after-convert transfer) in progress |
| sclk | output | 1 | Serial clock |
| sync | output | 1 | Frame strobe |
| sdout | output | 1 | Serial data, MSB first |

## Verification
Take cycle 0 as the edge that samples conv_start. Busy is due from the sample after that edge. In read-during-convert mode the first frame cycle is due 2*HALF_DIV edges later. In read-after-convert mode it is due one edge after the edge that samples conv_done, and busy ends 32*HALF_DIV edges after that. The bench drives inputs on falling edges and samples every output on every falling edge of each run. It compares them with a waveform computed from the edge count, so any shift of a single cycle in a clock, data, strobe or busy transition is caught.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned HALF_DIV_DEF = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_TAIL = 2'd2
    } conv_phase_t;

    typedef struct packed {
        logic load;
        logic go;
    } shift_cmd_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned HALF_DIV = HALF_DIV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] result,
    input  logic              rdc_mode,
    input  logic              master_en,
    input  logic              frame_active,
    input  logic              frame_end,
    output logic              busy,
    output shift_cmd_t        cmd,
    output logic [WORD_W-1:0] load_word
);
    localparam int unsigned WAIT_W = cnt_w(2 * HALF_DIV);

    conv_phase_t       ph_q;
    logic              mode_q;
    logic              wait_q;
    logic [WAIT_W-1:0] wait_cnt;
    logic [WORD_W-1:0] prev_q;

    logic start_ok, done_ok, launch_rar, launch_rdc, arm_rdc;

    always_comb begin
        start_ok   = conv_start && (ph_q == PH_IDLE) && !wait_q && !frame_active;
        done_ok    = conv_done && (ph_q == PH_CONV);
        arm_rdc    = start_ok && rdc_mode && master_en;
        launch_rar = done_ok && !mode_q && master_en;
        launch_rdc = wait_q && (wait_cnt == '0);
        cmd.load   = arm_rdc || launch_rar;
        cmd.go     = launch_rar || launch_rdc;
        load_word  = launch_rar ? result : prev_q;
        busy       = (ph_q != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            mode_q   <= 1'b0;
            wait_q   <= 1'b0;
            wait_cnt <= '0;
            prev_q   <= '0;
        end else begin
            if (start_ok) begin
                ph_q   <= PH_CONV;
                mode_q <= rdc_mode;
            end else if (done_ok) begin
                prev_q <= result;
                ph_q   <= launch_rar ? PH_TAIL : PH_IDLE;
            end else if ((ph_q == PH_TAIL) && frame_end) begin
                ph_q <= PH_IDLE;
            end

            if (arm_rdc) begin
                wait_q   <= 1'b1;
                wait_cnt <= WAIT_W'(2 * HALF_DIV - 1);
            end else if (wait_q) begin
                if (wait_cnt == '0) wait_q <= 1'b0;
                else                wait_cnt <= wait_cnt - 1'b1;
            end
        end
    end

    // R7: the latched mode holds for the whole busy interval
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(mode_q)));

    // R5: a read-after-convert tail lasts exactly while the shifter runs
    p_tail_tracks_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_TAIL) |-> frame_active);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned HALF_DIV = HALF_DIV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_cmd_t        cmd,
    input  logic [WORD_W-1:0] load_word,
    output logic              active,
    output logic              frame_end,
    output logic              sclk_raw,
    output logic              sdout_raw
);
    localparam int unsigned HW = cnt_w(HALF_DIV);
    localparam int unsigned BW = cnt_w(WORD_W);

    logic              active_q, phase_q;
    logic [HW-1:0]     half_q;
    logic [BW-1:0]     bit_q;
    logic [WORD_W-1:0] sh_q;
    logic              half_last, bit_last;

    always_comb begin
        half_last = (half_q == HW'(HALF_DIV - 1));
        bit_last  = (bit_q == BW'(WORD_W - 1));
        frame_end = active_q && half_last && phase_q && bit_last;
        active    = active_q;
        sclk_raw  = active_q && phase_q;
        sdout_raw = active_q && sh_q[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
        end else begin
            if (cmd.load) begin
                sh_q <= load_word;
            end else if (active_q && half_last && phase_q) begin
                sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end

            if (cmd.go) begin
                active_q <= 1'b1;
                phase_q  <= 1'b0;
                half_q   <= '0;
                bit_q    <= '0;
            end else if (active_q) begin
                if (half_last) begin
                    half_q <= '0;
                    if (phase_q) begin
                        phase_q <= 1'b0;
                        if (bit_last) active_q <= 1'b0;
                        else          bit_q <= bit_q + 1'b1;
                    end else begin
                        phase_q <= 1'b1;
                    end
                end else begin
                    half_q <= half_q + 1'b1;
                end
            end
        end
    end

    // checker counter: rising serial-clock phases seen in the current frame
    logic [BW:0] rise_cnt;
    always_ff @(posedge clk) begin
        if (rst || cmd.go)                          rise_cnt <= '0;
        else if (active_q && half_last && !phase_q) rise_cnt <= rise_cnt + 1'b1;
    end

    // R2: every frame has exactly WORD_W clock pulses
    p_pulse_count_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(active_q) |-> (rise_cnt == (BW+1)'(WORD_W)));

    // R2: data does not move while the serial clock is high
    p_data_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (active_q && phase_q && $past(active_q && phase_q)) |-> $stable(sh_q[WORD_W-1]));

endmodule

// File: rtl/sertx_pins.sv
module sertx_pins (
    input  logic gate,
    input  logic inv_sclk,
    input  logic inv_sync,
    input  logic sclk_raw,
    input  logic sync_raw,
    input  logic sdout_raw,
    output logic sclk,
    output logic sync,
    output logic sdout
);
    always_comb begin
        sclk  = (sclk_raw && !gate) ^ inv_sclk;
        sync  = (sync_raw && !gate) ^ inv_sync;
        sdout = sdout_raw && !gate;
    end
endmodule

// File: rtl/sertx_master.sv
module sertx_master
    import sertx_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned HALF_DIV = HALF_DIV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] result,
    input  logic              rdc_mode,
    input  logic              inv_sclk,
    input  logic              inv_sync,
    input  logic              ser_sel,
    input  logic              ext_clk_sel,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              busy,
    output logic              sclk,
    output logic              sync,
    output logic              sdout
);
    shift_cmd_t        cmd;
    logic [WORD_W-1:0] load_word;
    logic              frame_active, frame_end, sclk_raw, sdout_raw;
    logic              master_en, gate;

    assign master_en = ser_sel && !ext_clk_sel;
    assign gate      = cs_n || rd_n;

    sertx_ctrl #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_ctrl (
        .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
        .result(result), .rdc_mode(rdc_mode), .master_en(master_en),
        .frame_active(frame_active), .frame_end(frame_end),
        .busy(busy), .cmd(cmd), .load_word(load_word)
    );

    sertx_shifter #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .cmd(cmd), .load_word(load_word),
        .active(frame_active), .frame_end(frame_end),
        .sclk_raw(sclk_raw), .sdout_raw(sdout_raw)
    );

    sertx_pins u_pins (
        .gate(gate), .inv_sclk(inv_sclk), .inv_sync(inv_sync),
        .sclk_raw(sclk_raw), .sync_raw(frame_active), .sdout_raw(sdout_raw),
        .sclk(sclk), .sync(sync), .sdout(sdout)
    );

    // R3: the shifter presents no data outside a frame
    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !frame_active |-> !sdout_raw);

endmodule

// File: tb/sim_sertx_master.sv
module sim_sertx_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst, conv_start, conv_done, rdc_mode, inv_sclk, inv_sync;
    logic ser_sel, ext_clk_sel, cs_n, rd_n;
    logic [15:0] result;
    logic busy, sclk, sync, sdout;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] prev_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_master #(.WORD_W(16), .HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
        .result(result), .rdc_mode(rdc_mode), .inv_sclk(inv_sclk), .inv_sync(inv_sync),
        .ser_sel(ser_sel), .ext_clk_sel(ext_clk_sel), .cs_n(cs_n), .rd_n(rd_n),
        .busy(busy), .sclk(sclk), .sync(sync), .sdout(sdout)
    );

    task automatic check(input string tag, input int n, input logic [3:0] got, input logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d {busy,sclk,sync,sdout} got %b expected %b", tag, n, got, exp);
        end
    endtask

    // one conversion; d = edge index that samples conv_done (start sampled at edge 0)
    task automatic run_conv(input bit rdc, input logic [15:0] nw, input int d,
                            input int restart_at, input string tag);
        int s, flen, last, busy_end, p;
        bit master, gate, act, sck, sd;
        logic [15:0] fd;
        logic [3:0] expv;
        master   = ser_sel && !ext_clk_sel;
        gate     = cs_n || rd_n;
        flen     = 32 * HALF;
        s        = rdc ? 2 * HALF : d;
        fd       = rdc ? prev_m : nw;
        busy_end = (!rdc && master) ? d + flen : d;
        last     = ((s > d) ? s : d) + flen + 3;
        rdc_mode   = rdc;
        result     = nw;
        conv_start = 1'b1;
        for (int n = 1; n <= last; n++) begin
            @(posedge clk);
            @(negedge clk);
            act = master && (n >= s + 1) && (n <= s + flen);
            sck = 1'b0;
            sd  = 1'b0;
            if (act) begin
                p   = n - s - 1;
                sck = (p % (2 * HALF)) >= HALF;
                sd  = fd[15 - p / (2 * HALF)];
            end
            expv = {n <= busy_end,
                    gate ? inv_sclk : (sck ^ inv_sclk),
                    gate ? inv_sync : (act ^ inv_sync),
                    gate ? 1'b0 : sd};
            check(tag, n, {busy, sclk, sync, sdout}, expv);
            conv_start = (n == restart_at);
            rdc_mode   = (n == restart_at) ? !rdc : rdc;
            conv_done  = (n == d);
        end
        conv_done  = 1'b0;
        conv_start = 1'b0;
        rdc_mode   = rdc;
        prev_m     = nw;
    endtask

    initial begin
        rst = 1'b1; conv_start = 1'b0; conv_done = 1'b0; rdc_mode = 1'b0;
        inv_sclk = 1'b0; inv_sync = 1'b0; ser_sel = 1'b1; ext_clk_sel = 1'b0;
        cs_n = 1'b0; rd_n = 1'b0; result = '0; prev_m = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset idle", 0, {busy, sclk, sync, sdout}, 4'b0000);

        // R8: stray conv_done while idle must change nothing
        conv_done = 1'b1; result = 16'hDEAD;
        @(posedge clk);
        @(negedge clk);
        conv_done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R8 idle done ignored", i, {busy, sclk, sync, sdout}, 4'b0000);
        end
        // R6 and R8: first read-during-convert frame carries the reset value 0
        run_conv(1'b1, 16'h1234, 70, 0, "R6/R8 first rdc frame");

        // R2 R3 R4 R5 R6: sweep modes and polarities
        for (int m = 0; m < 2; m++) begin
            for (int ic = 0; ic < 2; ic++) begin
                for (int iy = 0; iy < 2; iy++) begin
                    inv_sclk = ic[0];
                    inv_sync = iy[0];
                    run_conv(m[0], 16'hA5C3 ^ 16'((m * 4 + ic * 2 + iy) * 16'h1357),
                             m ? 80 : 20 + ic * 3, 0,
                             m ? "R6/R4/R2 rdc sweep" : "R5/R4/R3 rar sweep");
                end
            end
        end
        inv_sclk = 1'b0; inv_sync = 1'b0;

        // R2: boundary data words
        run_conv(1'b0, 16'hFFFF, 7, 0, "R2 all ones");
        run_conv(1'b0, 16'h8001, 9, 0, "R2 end bits");
        run_conv(1'b1, 16'h0001, 75, 0, "R2 rdc sends 8001");
        // R6: conversion ends before the frame starts
        run_conv(1'b1, 16'h4C2B, 2, 0, "R6 short conversion");
        run_conv(1'b1, 16'h0F0F, 90, 0, "R6 sends short-conv word");

        // R7: restart attempts while busy / frame running are ignored
        run_conv(1'b0, 16'h3E71, 30, 5, "R7 restart during conversion");
        run_conv(1'b1, 16'h6A95, 80, 12, "R7 restart during frame");

        // R9: master mode disabled
        ser_sel = 1'b0;
        run_conv(1'b0, 16'h1111, 15, 0, "R9 parallel select rar");
        ser_sel = 1'b1; ext_clk_sel = 1'b1;
        run_conv(1'b1, 16'h2222, 40, 0, "R9 external clock rdc");
        ext_clk_sel = 1'b0;

        // R10: gated outputs
        cs_n = 1'b1;
        run_conv(1'b0, 16'h5A5A, 12, 0, "R10 cs_n high");
        cs_n = 1'b0; rd_n = 1'b1; inv_sclk = 1'b1; inv_sync = 1'b1;
        run_conv(1'b1, 16'h7777, 70, 0, "R10 rd_n high inverted");
        rd_n = 1'b0;
        run_conv(1'b1, 16'h0000, 70, 0, "R10 ungated after gate");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule